// File: doc/BRIEF.md
# NMI Trigger Detect and Latch

This block conditions a single external non-maskable interrupt pad for an always-on interrupt controller. The pad is first brought into the clock domain through a two-flop synchronizer. A 2-bit trigger code then chooses the active polarity and whether the pad is treated as a level or as an edge. A qualifying event sets a sticky latch. Software clears the latch by writing a 1 to bit 0 of the pending word.

The parent interrupt controller never sees the pad directly. It sees the latch, gated by enable bit 0, as an active-high level request, and the trigger code does not change that. A small register port sets the trigger code and the enable bit. The same port reads back the code, the enable bit and the gated pending state.

Top module: `nmi_trigger_latch`

## Requirements
- R1: After reset the latch is 0, the trigger code is 0 (level low), enable bit 0 is 0, and `nmi_req` is 0.
- R2: Register map (byte offsets on `reg_addr`): the trigger code is bits [1:0] at 0x0c, the pending flag is bit 0 at 0x10, and the enable flag is bit 0 at 0x40. All other bits, and every other offset, read as 0.
- R3: Trigger codes: 0 is level low, 1 is falling edge, 2 is level high and 3 is rising edge. A pad change driven between clock edges is reflected in the latch on the third rising clock edge that follows, and not earlier.
- R4: In the level modes the latch sets while the pad holds the active level. A clear that arrives while that level is still present leaves the latch set, because set wins over clear.
- R5: In the edge modes a single transition of the selected direction sets the latch. The latch stays set after the pad returns. A transition in the other direction, or a steady pad, does not set it.
- R6: A write to the pending word with bit 0 = 1 clears the latch when no set is active. A write with bit 0 = 0 leaves the latch unchanged.
- R7: Enable bit 0 gates both `nmi_req` and the pending bit that is read back. The latch itself is kept while the block is disabled, and it shows again when the enable bit is set.
- R8: `nmi_req` is an active-high level equal to the gated latch in every trigger mode, and it stays high until a clear.
- R9: A write to the trigger code does not by itself create an edge event. For example, switching from falling to rising while the pad is held high leaves the latch clear.
- R10: Without a set event or a clear, the latch keeps its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | 1 | Asynchronous NMI pad |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| nmi_req | output | 1 | Level-high request to the parent controller |

## Verification
The assertions check four things on every cycle: set wins over a simultaneous clear, a clear with no set drops the latch, the latch holds when it is neither set nor cleared, and every rise of the latch follows a cycle in which the conditioned pad was active. They also check that a disabled block never raises the request. Only the bench scenarios can show three further behaviours. The first is the exact three-edge latency from pad to latch. The second is the full mapping of each trigger code to its polarity and edge. The third is that rewriting the trigger code with the pad held steady produces no false edge.

// File: rtl/nmi_trigger_latch.sv
module nmi_trigger_latch #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFS = 'h0c,
  parameter int PEND_OFS = 'h10,
  parameter int EN_OFS   = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              nmi_req
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFS);

  logic [1:0] sync_q;
  logic [1:0] trig_q;
  logic       prev_q;
  logic       latch_q;
  logic       en_q;

  // trig[1] = active high, trig[0] = edge sensitive
  wire ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  wire clr      = reg_wr && (reg_addr == A_PEND) && reg_wdata[0];
  wire en_wr    = reg_wr && (reg_addr == A_EN);
  wire pad_s    = sync_q[1];
  wire cond     = pad_s ^ ~trig_q[1];
  wire cond_new = pad_s ^ ~reg_wdata[1];
  wire set      = trig_q[0] ? (cond & ~prev_q & ~ctrl_wr) : cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      trig_q  <= 2'd0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pad_in};
      if (ctrl_wr) begin
        trig_q <= reg_wdata[1:0];
        prev_q <= cond_new;
      end else begin
        prev_q <= cond;
      end
      if (en_wr) en_q <= reg_wdata[0];
      if (set)      latch_q <= 1'b1;
      else if (clr) latch_q <= 1'b0;
    end
  end

  assign nmi_req = latch_q & en_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[1:0] = trig_q;
      A_PEND:  reg_rdata[0]   = latch_q & en_q;
      A_EN:    reg_rdata[0]   = en_q;
      default: reg_rdata      = '0;
    endcase
  end

  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set && clr) |=> latch_q);

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !latch_q);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(latch_q));

  a_r3_rise_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(cond));

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !nmi_req);

endmodule

// File: tb/nmi_trigger_latch_test.sv
module nmi_trigger_latch_test;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0, pad_in = 0, reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic nmi_req;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  nmi_trigger_latch uut (.clk(clk), .rst_n(rst_n), .pad_in(pad_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_req(nmi_req));

  // {mode[1:0], pad_before, pad_after, expected latch}
  localparam logic [4:0] VEC [10] = '{
    5'b00_1_0_1, 5'b00_1_1_0,
    5'b01_1_0_1, 5'b01_0_1_0, 5'b01_0_0_0,
    5'b10_0_1_1, 5'b10_0_0_0,
    5'b11_0_1_1, 5'b11_1_0_0, 5'b11_1_1_0
  };

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    wait_cyc(3);
    rst_n = 1;
    // R1 / R2 reset state and map
    rd(8'h0c, d); check("R1 ctrl reset", d, 0);
    rd(8'h40, d); check("R1 enable reset", d, 0);
    rd(8'h10, d); check("R1 pending reset", d, 0);
    check("R1 req reset", nmi_req, 0);
    wr(8'h0c, 32'hffff_fffe);
    rd(8'h0c, d); check("R2 ctrl field width", d, 2);
    rd(8'h24, d); check("R2 unmapped offset", d, 0);
    wr(8'h40, 32'hffff_ffff);
    rd(8'h40, d); check("R2 enable field width", d, 1);

    // table walk: R3 R4 R5 R8
    foreach (VEC[i]) begin
      pad_in = VEC[i][2];
      wait_cyc(4);
      wr(8'h0c, {30'd0, VEC[i][4:3]});
      wait_cyc(4);
      wr(8'h10, 1);
      wait_cyc(2);
      pad_in = VEC[i][1];
      wait_cyc(4);
      rd(8'h10, d);
      check($sformatf("R3/R5 vec%0d pending", i), d, {31'd0, VEC[i][0]});
      check($sformatf("R8 vec%0d req", i), nmi_req, VEC[i][0]);
    end

    // R3 latency: mode level high
    pad_in = 0;
    wr(8'h0c, 2);
    wait_cyc(4);
    wr(8'h10, 1);
    wait_cyc(1);
    reg_addr = 8'h10;
    @(negedge clk); pad_in = 1;
    @(negedge clk); @(negedge clk);
    check("R3 not before third edge", nmi_req, 0);
    @(negedge clk);
    check("R3 at third edge", nmi_req, 1);

    // R4 clear while level still present
    wr(8'h10, 1);
    wait_cyc(1);
    rd(8'h10, d); check("R4 set wins over clear", d, 1);
    pad_in = 0;
    wait_cyc(4);
    wr(8'h10, 1);
    rd(8'h10, d); check("R6 clear once inactive", d, 0);

    // R5 edge: latch sticks after pad returns
    wr(8'h0c, 3);
    wait_cyc(2);
    pad_in = 1; wait_cyc(2); pad_in = 0; wait_cyc(4);
    rd(8'h10, d); check("R5 edge sticks", d, 1);

    // R6 write 0 ignored
    wr(8'h10, 32'hffff_fffe);
    rd(8'h10, d); check("R6 write zero ignored", d, 1);

    // R7 enable gating
    wr(8'h40, 0);
    rd(8'h10, d); check("R7 pending gated", d, 0);
    check("R7 req gated", nmi_req, 0);
    wr(8'h40, 1);
    rd(8'h10, d); check("R7 latch kept", d, 1);
    check("R8 req level high", nmi_req, 1);

    // R9 mode rewrite with pad held high
    pad_in = 1;
    wr(8'h0c, 1);
    wait_cyc(4);
    wr(8'h10, 1);
    wait_cyc(1);
    wr(8'h0c, 3);
    wait_cyc(4);
    rd(8'h10, d); check("R9 no false edge", d, 0);
    // R10 latch holds with no activity
    wait_cyc(10);
    rd(8'h10, d); check("R10 hold clear", d, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule